// File: doc/BRIEF.md
# Pixel Response Nonuniformity Meter

The meter watches the sample stream of one sensor output channel while the sensor sees a uniformly lit target. It groups the effective pixels of each line into fixed blocks of `BLK_PIX` consecutive pixels. Inside a block the pixels at odd positions (first, third, ...) and those at even positions are tracked apart: for each parity it keeps the smallest sample, the largest sample and the running sum.

When a block closes, a sequential shift-subtract divider works out, for the odd set and then for the even set, the nonuniformity figure: half the peak-to-peak spread divided by the mean, expressed in percent. Each result is reported with its parity, its block number, a pass flag against a programmable threshold, and an error flag for a zero mean. The worst figure seen since the last line start is held on a separate output, so that a line can be judged as a whole.

Top module: `prnu_meter`

## Requirements
- R1: After reset `res_valid` is 0 and `worst_pct` is 0.
- R2: A sample is taken only in a cycle with `smp_valid` = 1, `smp_eff` = 1 and `line_start` = 0; any other sample leaves the statistics and the pixel position unchanged.
- R3: Every `BLK_PIX` taken samples form one block. Samples 1, 3, 5, ... of a block form the odd set and samples 2, 4, ... form the even set. Each closed block yields exactly two results, the odd set first (`res_even` = 0), then the even set (`res_even` = 1), both carrying the block number `res_blk`, counted from 0 at the line start.
- R4: `res_pct` = floor((max - min) * 50 * N * 2^FB / sum), where N = `BLK_PIX`/2 and max, min and sum are taken over one set. This is (max-min)/2 divided by the mean, times 100, in fixed point with FB fractional bits (FB = 4: one LSB = 1/16 percent).
- R5: A set whose sum is zero gives `res_err` = 1, `res_pct` = all ones and `res_pass` = 0.
- R6: `res_pass` = 1 exactly when `res_err` = 0 and `res_pct` <= `thr_pct` (the threshold in the same fixed-point format as `res_pct`).
- R7: `worst_pct` equals the largest `res_pct` reported since the last `line_start`; `line_start` clears it to 0 in the next cycle.
- R8: `line_start` drops any partly collected block and restarts both the pixel position and the block number at 0.
- R9: `res_valid` is a one-cycle pulse per result, and the divider takes several cycles per result, so two results never appear in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the start of a line |
| smp_valid | input | 1 | Sample present on `smp_data` |
| smp_eff | input | 1 | Sample belongs to an effective pixel |
| smp_data | input | DW | Pixel sample value |
| thr_pct | input | QW | Pass threshold, 1/2^FB percent per LSB |
| res_valid | output | 1 | Result pulse |
| res_even | output | 1 | 0 for the odd set, 1 for the even set |
| res_blk | output | BIW | Block number within the line |
| res_pct | output | QW | Nonuniformity figure, 1/2^FB percent per LSB |
| res_pass | output | 1 | Result within threshold |
| res_err | output | 1 | Zero-mean set, result saturated |
| worst_pct | output | QW | Largest result since the last line start |

## Verification
The assertions take for granted that a new block never closes while the two divisions of the previous block are still running, and that the block length is even; the bench keeps to this by leaving a quiet stretch of well over two division times after each block. The stimulus interleaves samples with the valid or effective flag low carrying a zero value, and drives a sample alongside each line start, so that any wrongly taken sample would pull a minimum or a sum off its expected value. Threshold equality, a zero-sum set, a flat set and a partial block cut short by a line start are all driven on purpose.

// File: rtl/prnu_pkg.sv
// Shared definitions for the nonuniformity meter.
// Assumes: the percentage scale is 50 * (pixels per set) * 2^FB.
package prnu_pkg;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_WAIT = 1'b1
    } seq_state_t;

    // Scale constant that turns range/sum into half-range over mean in percent.
    function automatic int unsigned pct_scale(input int unsigned npar, input int unsigned fb);
        return (50 * npar) << fb;
    endfunction

endpackage

// File: rtl/prnu_blk_stats.sv
// Minimum, maximum and sum tracker for one pixel set of a block.
// Assumes: 'first' is raised with the first update of each block so the
// registers reload instead of accumulating across blocks.
module prnu_blk_stats #(
    parameter int DW   = 12,
    parameter int NPAR = 50,
    localparam int SW  = DW + $clog2(NPAR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          first,
    input  logic [DW-1:0] smp,
    output logic [DW-1:0] min_o,
    output logic [DW-1:0] max_o,
    output logic [SW-1:0] sum_o
);

    // Update the three running statistics on each taken sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_o <= '0;
            max_o <= '0;
            sum_o <= '0;
        end else if (upd) begin
            if (first) begin
                min_o <= smp;
                max_o <= smp;
                sum_o <= SW'(smp);
            end else begin
                if (smp < min_o) min_o <= smp;
                if (smp > max_o) max_o <= smp;
                sum_o <= sum_o + SW'(smp);
            end
        end
    end

    AST_MAX_COVERS_SMP: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (max_o >= $past(smp)) && (min_o <= $past(smp))); // R3

endmodule

// File: rtl/prnu_seq_div.sv
// Restoring shift-subtract divider, one quotient bit per cycle.
// Assumes: 'start' is only raised while idle. A zero divisor finishes in
// one cycle with 'dz' set and an all-ones quotient.
module prnu_seq_div #(
    parameter int NW  = 28,
    parameter int DNW = 18,
    localparam int CW = $clog2(NW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [NW-1:0]  num,
    input  logic [DNW-1:0] den,
    output logic           busy,
    output logic           done,
    output logic [NW-1:0]  quo,
    output logic           dz
);

    logic [DNW-1:0] den_q;
    logic [DNW-1:0] rem;
    logic [CW-1:0]  cnt;
    logic [DNW:0]   rem_sh;
    logic           ge;
    logic [DNW-1:0] rem_nx;

    // One restoring step: shift in the next dividend bit and try a subtract.
    always_comb begin
        rem_sh = {rem, quo[NW-1]};
        ge     = rem_sh >= {1'b0, den_q};
        rem_nx = ge ? DNW'(rem_sh - {1'b0, den_q}) : rem_sh[DNW-1:0];
    end

    // Launch, iterate and finish a division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            dz    <= 1'b0;
            quo   <= '0;
            rem   <= '0;
            den_q <= '0;
            cnt   <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                if (den == '0) begin
                    dz   <= 1'b1;
                    quo  <= '1;
                    done <= 1'b1;
                end else begin
                    dz    <= 1'b0;
                    busy  <= 1'b1;
                    quo   <= num;
                    rem   <= '0;
                    den_q <= den;
                    cnt   <= CW'(NW - 1);
                end
            end else if (busy) begin
                rem <= rem_nx;
                quo <= {quo[NW-2:0], ge};
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DIV_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R9

endmodule

// File: rtl/prnu_meter.sv
// Pixel response nonuniformity meter for one sensor output channel.
// Splits effective pixels into blocks of BLK_PIX, tracks odd and even
// sets apart, and reports (max-min)/2 over mean in percent per set.
// Assumes: BLK_PIX is even, and a block never closes while the two
// divisions of the previous block are still in progress.
module prnu_meter
    import prnu_pkg::*;
#(
    parameter int DW      = 12,
    parameter int BLK_PIX = 100,
    parameter int FB      = 4,
    parameter int QW      = 16,
    parameter int BIW     = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           line_start,
    input  logic           smp_valid,
    input  logic           smp_eff,
    input  logic [DW-1:0]  smp_data,
    input  logic [QW-1:0]  thr_pct,
    output logic           res_valid,
    output logic           res_even,
    output logic [BIW-1:0] res_blk,
    output logic [QW-1:0]  res_pct,
    output logic           res_pass,
    output logic           res_err,
    output logic [QW-1:0]  worst_pct
);

    localparam int NPAR = BLK_PIX / 2;
    localparam int SW   = DW + $clog2(NPAR + 1);
    localparam int unsigned KSC = pct_scale(NPAR, FB);
    localparam int KW   = $clog2(KSC + 1);
    localparam int NW   = DW + KW;
    localparam int PCW  = $clog2(BLK_PIX);
    localparam logic [NW-1:0] QLIM = NW'((64'd1 << QW) - 1);

    logic           take;
    logic           last_pix;
    logic [PCW-1:0] pix_cnt;
    logic [BIW-1:0] blk_cnt;
    logic           blk_end_q;
    logic [BIW-1:0] blk_id_q;

    logic [DW-1:0]  st_min [2];
    logic [DW-1:0]  st_max [2];
    logic [SW-1:0]  st_sum [2];

    logic [DW-1:0]  pend_rng [2];
    logic [SW-1:0]  pend_sum [2];
    logic [BIW-1:0] pend_blk;

    seq_state_t     state;
    logic           sel;
    logic           go_q;
    logic [NW-1:0]  div_num;
    logic [SW-1:0]  div_den;
    logic           div_busy;
    logic           div_done;
    logic [NW-1:0]  div_quo;
    logic           div_dz;
    logic [QW-1:0]  quo_sat;

    // Qualify a sample and spot the last pixel of a block.
    always_comb begin
        take     = smp_valid && smp_eff && !line_start;
        last_pix = pix_cnt == PCW'(BLK_PIX - 1);
    end

    // Track pixel position, block number and the block-closed strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_cnt   <= '0;
            blk_cnt   <= '0;
            blk_end_q <= 1'b0;
            blk_id_q  <= '0;
        end else begin
            blk_end_q <= take && last_pix;
            if (line_start) begin
                pix_cnt <= '0;
                blk_cnt <= '0;
            end else if (take) begin
                if (last_pix) begin
                    pix_cnt  <= '0;
                    blk_cnt  <= blk_cnt + 1'b1;
                    blk_id_q <= blk_cnt;
                end else begin
                    pix_cnt <= pix_cnt + 1'b1;
                end
            end
        end
    end

    // One statistics tracker per parity; index 0 holds the odd set.
    for (genvar p = 0; p < 2; p++) begin : g_par
        prnu_blk_stats #(
            .DW   (DW),
            .NPAR (NPAR)
        ) u_stats (
            .clk   (clk),
            .rst_n (rst_n),
            .upd   (take && (pix_cnt[0] == 1'(p))),
            .first (pix_cnt < PCW'(2)),
            .smp   (smp_data),
            .min_o (st_min[p]),
            .max_o (st_max[p]),
            .sum_o (st_sum[p])
        );
    end

    // Pick the operands of the set being divided.
    always_comb begin
        div_num = NW'(pend_rng[sel]) * NW'(KSC);
        div_den = pend_sum[sel];
        quo_sat = (div_quo > QLIM) ? QW'(QLIM) : QW'(div_quo);
    end

    // Capture a closed block and run the odd then even division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            sel      <= 1'b0;
            go_q     <= 1'b0;
            pend_blk <= '0;
            for (int p = 0; p < 2; p++) begin
                pend_rng[p] <= '0;
                pend_sum[p] <= '0;
            end
        end else begin
            go_q <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (blk_end_q) begin
                        for (int p = 0; p < 2; p++) begin
                            pend_rng[p] <= st_max[p] - st_min[p];
                            pend_sum[p] <= st_sum[p];
                        end
                        pend_blk <= blk_id_q;
                        sel      <= 1'b0;
                        go_q     <= 1'b1;
                        state    <= SQ_WAIT;
                    end
                end
                default: begin
                    if (div_done) begin
                        if (!sel) begin
                            sel  <= 1'b1;
                            go_q <= 1'b1;
                        end else begin
                            state <= SQ_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    prnu_seq_div #(
        .NW  (NW),
        .DNW (SW)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go_q),
        .num   (div_num),
        .den   (div_den),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (div_quo),
        .dz    (div_dz)
    );

    // Register each finished result with its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_even  <= 1'b0;
            res_blk   <= '0;
            res_pct   <= '0;
            res_pass  <= 1'b0;
            res_err   <= 1'b0;
        end else begin
            res_valid <= div_done;
            if (div_done) begin
                res_even <= sel;
                res_blk  <= pend_blk;
                res_err  <= div_dz;
                res_pct  <= div_dz ? '1 : quo_sat;
                res_pass <= !div_dz && (quo_sat <= thr_pct);
            end
        end
    end

    // Hold the largest result of the current line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            worst_pct <= '0;
        end else if (line_start) begin
            worst_pct <= '0;
        end else if (res_valid && (res_pct > worst_pct)) begin
            worst_pct <= res_pct;
        end
    end

    AST_NO_BLOCK_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end_q |-> (state == SQ_IDLE) && !div_busy); // R3
    AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R9
    AST_ERR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err) |-> (res_pct == '1) && !res_pass); // R5
    AST_PCT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_err) |-> (QW'(res_pct) <= QW'(KSC))); // R4
    AST_WORST_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !line_start) |=> worst_pct >= $past(res_pct)); // R7
    AST_WORST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> worst_pct == '0); // R7

endmodule

// File: tb/prnu_meter_test.sv
// Scoreboard bench: the block driver queues expected results, a monitor
// pops and compares them whenever the design reports one.
module prnu_meter_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW  = 8;
    localparam int BLK = 8;
    localparam int FB  = 4;
    localparam int QW  = 16;
    localparam int BIW = 6;
    localparam longint KSC = 50 * (BLK / 2) * (1 << FB);

    typedef struct packed {
        logic           even;
        logic [BIW-1:0] blk;
        logic [QW-1:0]  pct;
        logic           pass;
        logic           err;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           line_start = 1'b0;
    logic           smp_valid = 1'b0;
    logic           smp_eff = 1'b0;
    logic [DW-1:0]  smp_data = '0;
    logic [QW-1:0]  thr_pct = '0;
    logic           res_valid;
    logic           res_even;
    logic [BIW-1:0] res_blk;
    logic [QW-1:0]  res_pct;
    logic           res_pass;
    logic           res_err;
    logic [QW-1:0]  worst_pct;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 0;
    exp_t expq[$];
    logic [QW-1:0] exp_worst;
    int   blk_no;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prnu_meter #(
        .DW (DW), .BLK_PIX (BLK), .FB (FB), .QW (QW), .BIW (BIW)
    ) uut (
        .clk (clk), .rst_n (rst_n), .line_start (line_start),
        .smp_valid (smp_valid), .smp_eff (smp_eff), .smp_data (smp_data),
        .thr_pct (thr_pct), .res_valid (res_valid), .res_even (res_even),
        .res_blk (res_blk), .res_pct (res_pct), .res_pass (res_pass),
        .res_err (res_err), .worst_pct (worst_pct)
    );

    function automatic exp_t calc(input int v[BLK], input int par, input int blk,
                                  input int thr);
        exp_t e;
        longint mn = 1 << 30, mx = 0, sm = 0;
        for (int i = par; i < BLK; i += 2) begin
            if (v[i] < mn) mn = v[i];
            if (v[i] > mx) mx = v[i];
            sm += v[i];
        end
        e.even = 1'(par);
        e.blk  = BIW'(blk);
        if (sm == 0) begin
            e.err  = 1'b1;
            e.pct  = '1;
            e.pass = 1'b0;
        end else begin
            e.err  = 1'b0;
            e.pct  = QW'(((mx - mn) * KSC) / sm);
            e.pass = (longint'(e.pct) <= thr);
        end
        return e;
    endfunction

    task automatic note_worst(input exp_t e);
        if (e.pct > exp_worst) exp_worst = e.pct;
    endtask

    // One cycle with a given input set, driven at the falling edge.
    task automatic drive(input logic ls, input logic v, input logic ef, input int d);
        @(negedge clk);
        line_start = ls;
        smp_valid  = v;
        smp_eff    = ef;
        smp_data   = DW'(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 0);
    endtask

    // Start a line; a sample driven alongside must be ignored (R2, R8).
    task automatic new_line();
        drive(1'b1, 1'b1, 1'b1, 0);
        exp_worst = '0;
        blk_no    = 0;
        idle(2);
    endtask

    // Push the two expected results, then drive one block with junk between pixels (R2).
    task automatic run_block(input int v[BLK], input int thr);
        exp_t eo, ee;
        thr_pct = QW'(thr);
        eo = calc(v, 0, blk_no, thr);
        ee = calc(v, 1, blk_no, thr);
        expq.push_back(eo);
        expq.push_back(ee);
        note_worst(eo);
        note_worst(ee);
        for (int i = 0; i < BLK; i++) begin
            drive(1'b0, 1'b1, 1'b1, v[i]);
            drive(1'b0, 1'b1, 1'b0, 0);
            drive(1'b0, 1'b0, 1'b1, 0);
        end
        blk_no++;
        idle(90);
    endtask

    // Monitor: compare every reported result against the queue head.
    always @(negedge clk) begin
        if (rst_n && res_valid && !finished) begin
            n_checks++;
            if (expq.size() == 0) begin
                n_fails++;
                $display("FAIL R3 unexpected result: pct=%0d even=%0d blk=%0d, expected none",
                         res_pct, res_even, res_blk);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (res_pct !== e.pct || res_err !== e.err || res_pass !== e.pass ||
                    res_even !== e.even || res_blk !== e.blk) begin
                    n_fails++;
                    $display("FAIL R3 R4 R5 R6 result: pct=%0d err=%0d pass=%0d even=%0d blk=%0d, expected pct=%0d err=%0d pass=%0d even=%0d blk=%0d",
                             res_pct, res_err, res_pass, res_even, res_blk,
                             e.pct, e.err, e.pass, e.even, e.blk);
                end
            end
        end
    end

    task automatic check_worst(input string tag);
        @(negedge clk);
        n_checks++;
        if (worst_pct !== exp_worst) begin
            n_fails++;
            $display("FAIL %s worst_pct=%0d, expected %0d", tag, worst_pct, exp_worst);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired: elapsed=%0d, expected below %0d cycles", 150000, 150000);
        finish_run();
    end

    initial begin
        exp_worst = '0;
        blk_no    = 0;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        n_checks++;
        if (res_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 res_valid=%0d, expected 0", res_valid);
        end
        n_checks++;
        if (worst_pct !== '0) begin
            n_fails++;
            $display("FAIL R1 worst_pct=%0d, expected 0", worst_pct);
        end

        // Line 1: mixed spreads, flat set and zero-sum set (R3, R4, R5)
        new_line();
        run_block('{100, 50, 104, 52, 98, 48, 102, 50}, 80);
        run_block('{200, 10, 100, 10, 150, 10, 250, 10}, 80);
        run_block('{0, 7, 0, 9, 0, 5, 0, 3}, 80);
        check_worst("R7 line1");

        // Line 2: partial block cut by a new line start (R8)
        new_line();
        drive(1'b0, 1'b1, 1'b1, 3);
        drive(1'b0, 1'b1, 1'b1, 250);
        drive(1'b0, 1'b1, 1'b1, 1);
        idle(2);
        new_line();
        // Threshold equal to even result passes, one below fails (R6)
        run_block('{100, 50, 104, 52, 98, 48, 102, 50}, 64);
        run_block('{100, 50, 104, 52, 98, 48, 102, 50}, 63);
        check_worst("R7 line2");

        // Line start clears the worst value (R7)
        new_line();
        check_worst("R7 cleared");

        n_checks++;
        if (expq.size() != 0) begin
            n_fails++;
            $display("FAIL R9 results outstanding=%0d, expected 0", expq.size());
        end
        finish_run();
    end

endmodule